// File: doc/BRIEF.md
# Rate-Paced Parallel Pin Engine

This block moves words between software and a bank of up to `W` parallel pins at a fixed rate. Software writes words into a short output queue. A programmable divider produces a periodic tick. On each tick the oldest queued word is applied to every pin at once, so pin changes fall on an exact grid of clock cycles.

The same tick can also capture the pins into a sample queue. Software drains that queue through a valid/ready read port without blocking. A separate direct view returns the present pin state in the same cycle, with no queue in the path. A per-pin direction mask chooses which pins the block drives.

Top module: `rate_paced_pio`

## Requirements
- R1: `pin_oe` equals the `dir_mask` value seen at the previous clock edge. A mask bit of 1 makes that pin an output and 0 makes it an input.
- R2: The output queue holds at most `WQ_DEPTH` (4) words. `wr_ready` is low while 4 words are held. A word offered while `wr_ready` is low is not taken, and no pin changes because of it.
- R3: With divider count N, ticks are exactly N+1 cycles apart. The divider keeps running whether or not sampling is on. A count of 0 gives a tick on every cycle.
- R4: On a tick with a non-empty output queue, the oldest word is written to all bits of `pin_out` at the same edge. On a tick with an empty queue, and between ticks, `pin_out` keeps its value.
- R5: `direct_data` shows the live pin state in the same cycle. For each pin i it is `pin_out[i]` when `pin_oe[i]` is 1 and `pin_in[i]` when it is 0.
- R6: On a tick with `samp_en` high, the `direct_data` value is pushed into a sample queue of depth `RQ_DEPTH` (4). `rd_valid` is high while the queue is non-empty. `rd_data` is its oldest entry, which stays stable until it is removed by `rd_valid && rd_ready`.
- R7: When `samp_en` is first seen high at an edge, the divider restarts and no tick occurs at that edge. The first tick follows N+1 edges later.
- R8: If a sample is due while the sample queue is full and nothing is read in the same cycle, the sample is dropped and `samp_ovf` is set. `samp_ovf` stays set until `samp_en` is next turned on.
- R9: Synchronous active-high reset clears `pin_out`, `pin_oe` and `samp_ovf`, and empties both queues. After reset, `wr_ready` is 1 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Output word offered |
| wr_data | input | W | Output word |
| wr_ready | output | 1 | Output queue can take a word |
| div_count | input | DIV_W | Divider count N (period N+1) |
| dir_mask | input | W | Per-pin direction, 1 = drive |
| samp_en | input | 1 | Periodic sampling on |
| pin_in | input | W | Pin input levels |
| pin_out | output | W | Driven pin levels |
| pin_oe | output | W | Pin drive enables |
| direct_data | output | W | Live pin view |
| rd_valid | output | 1 | Sample available |
| rd_data | output | W | Oldest sample |
| rd_ready | input | 1 | Remove oldest sample |
| samp_ovf | output | 1 | Sticky sample-dropped flag |

## Verification
The hardest state to reach is a sample tick that arrives while the sample queue is full. It must be checked both with and without a read in the same cycle, and then followed by the overflow flag being cleared through a fresh `samp_en` rise. The stimulus holds `rd_ready` low across more than four ticks at a short divider count to fill the queue. It then drains the queue and toggles `samp_en`, timing the first capture after the rise to confirm the divider restart. A long pseudo-random phase then varies the divider, the direction mask, writes, reads and sampling on every cycle. This lands pops on full-queue ticks and writes on full output queues. A behavioural reference model checks all outputs on every cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W_DEF     = 32;
  localparam int unsigned PIO_DEPTH_DEF = 4;
  localparam int unsigned PIO_DIV_W_DEF = 8;
endpackage

// File: rtl/pio_divider.sv
module pio_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // >= keeps the period bounded if the limit is lowered mid-count
  assign tick = (cnt >= limit) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pio_fifo.sv
module pio_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          pop_ok, push_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rate_paced_pio.sv
module rate_paced_pio
  import pio_pkg::*;
#(
  parameter int unsigned W        = PIO_W_DEF,
  parameter int unsigned WQ_DEPTH = PIO_DEPTH_DEF,
  parameter int unsigned RQ_DEPTH = PIO_DEPTH_DEF,
  parameter int unsigned DIV_W    = PIO_DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [W-1:0]     wr_data,
  output logic             wr_ready,
  input  logic [DIV_W-1:0] div_count,
  input  logic [W-1:0]     dir_mask,
  input  logic             samp_en,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     direct_data,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data,
  input  logic             rd_ready,
  output logic             samp_ovf
);
  logic         en_q, rise, tick;
  logic         wq_full, wq_empty, rq_full, rq_empty;
  logic [W-1:0] wq_head, pin_view;
  logic         samp_due, samp_drop;

  assign rise = samp_en && !en_q;

  pio_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(rise), .limit(div_count), .tick(tick)
  );

  // per-pin view: driven level for outputs, pad level for inputs
  for (genvar i = 0; i < W; i++) begin : g_view
    assign pin_view[i] = pin_oe[i] ? pin_out[i] : pin_in[i];
  end
  assign direct_data = pin_view;

  assign wr_ready = !wq_full;

  pio_fifo #(.W(W), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst(rst),
    .push(wr_valid && wr_ready), .din(wr_data),
    .pop(tick), .dout(wq_head),
    .full(wq_full), .empty(wq_empty)
  );

  assign samp_due  = tick && samp_en;
  assign samp_drop = samp_due && rq_full && !(rd_ready && !rq_empty);

  pio_fifo #(.W(W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst(rst),
    .push(samp_due), .din(pin_view),
    .pop(rd_ready), .dout(rd_data),
    .full(rq_full), .empty(rq_empty)
  );
  assign rd_valid = !rq_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      pin_out  <= '0;
      pin_oe   <= '0;
      samp_ovf <= 1'b0;
    end else begin
      en_q   <= samp_en;
      pin_oe <= dir_mask;
      if (tick && !wq_empty) pin_out <= wq_head;
      if (rise)           samp_ovf <= 1'b0;
      else if (samp_drop) samp_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
  parameter int unsigned W     = 32,
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wq_full,
  input logic             wr_ready,
  input logic [DIV_W-1:0] div_count,
  input logic [W-1:0]     dir_mask,
  input logic [W-1:0]     pin_out,
  input logic [W-1:0]     pin_oe,
  input logic             samp_en,
  input logic             samp_ovf,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [W-1:0]     rd_data
);
  AST_OE_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_oe == $past(dir_mask)); // R1
  AST_WR_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    wq_full |-> !wr_ready); // R2
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && div_count != '0) |=> (!tick || div_count == '0)); // R3
  AST_OUT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pin_out)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (samp_ovf && !(samp_en && !$past(samp_en))) |=> samp_ovf); // R8
endmodule

bind rate_paced_pio pio_checker #(.W(W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wq_full(wq_full), .wr_ready(wr_ready),
  .div_count(div_count), .dir_mask(dir_mask), .pin_out(pin_out), .pin_oe(pin_oe),
  .samp_en(samp_en), .samp_ovf(samp_ovf), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/sim_rate_paced_pio.sv
module sim_rate_paced_pio;
  localparam int W = 32, D = 4, DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, wr_valid = 1'b0, samp_en = 1'b0, rd_ready = 1'b0;
  logic [W-1:0]  wr_data = '0, dir_mask = '0, pin_in = '0;
  logic [DW-1:0] div_count = '0;
  logic          wr_ready, rd_valid, samp_ovf;
  logic [W-1:0]  pin_out, pin_oe, direct_data, rd_data;

  rate_paced_pio #(.W(W), .WQ_DEPTH(D), .RQ_DEPTH(D), .DIV_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .div_count(div_count), .dir_mask(dir_mask), .samp_en(samp_en), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .direct_data(direct_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .samp_ovf(samp_ovf)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int           m_cnt = 0;
  logic [W-1:0] m_out = '0, m_oe = '0;
  logic         m_ovf = 1'b0, m_enq = 1'b0;
  logic [W-1:0] m_wq[$], m_sq[$];

  always @(posedge clk) begin : model
    logic rise, tick, wacc, spop;
    logic [W-1:0] view;
    if (rst) begin
      m_cnt = 0; m_out = '0; m_oe = '0; m_ovf = 1'b0; m_enq = 1'b0;
      m_wq.delete(); m_sq.delete();
    end else begin
      rise = samp_en && !m_enq;
      tick = (m_cnt >= int'(div_count)) && !rise;
      view = (m_out & m_oe) | (pin_in & ~m_oe);
      wacc = wr_valid && (m_wq.size() < D);
      spop = rd_ready && (m_sq.size() > 0);
      if (tick && m_wq.size() > 0) m_out = m_wq.pop_front();
      if (wacc) m_wq.push_back(wr_data);
      if (spop) void'(m_sq.pop_front());
      if (rise) m_ovf = 1'b0;
      else if (tick && samp_en) begin
        if (m_sq.size() < D) m_sq.push_back(view);
        else m_ovf = 1'b1;
      end
      m_cnt = (rise || tick) ? 0 : m_cnt + 1;
      m_enq = samp_en;
      m_oe  = dir_mask;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(pin_out == m_out, "R4 pin_out", pin_out, m_out);
      check(pin_oe == m_oe, "R1 pin_oe", pin_oe, m_oe);
      check(wr_ready == (m_wq.size() < D), "R2 wr_ready", W'(wr_ready), W'(m_wq.size() < D));
      check(direct_data == ((m_out & m_oe) | (pin_in & ~m_oe)), "R5 direct_data",
            direct_data, (m_out & m_oe) | (pin_in & ~m_oe));
      check(rd_valid == (m_sq.size() > 0), "R6 rd_valid", W'(rd_valid), W'(m_sq.size() > 0));
      if (m_sq.size() > 0) check(rd_data == m_sq[0], "R6 rd_data", rd_data, m_sq[0]);
      check(samp_ovf == m_ovf, "R8 samp_ovf", W'(samp_ovf), W'(m_ovf));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // offer one word and hold it until it is taken
  task automatic put(input logic [W-1:0] d);
    bit took;
    wr_valid = 1'b1; wr_data = d;
    do begin
      took = wr_ready;
      step();
    end while (!took);
    wr_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    repeat (3) step();
    // R9 reset state, sampled while reset is still asserted
    check(pin_out == '0 && pin_oe == '0, "R9 pins after reset", pin_out | pin_oe, '0);
    check(wr_ready && !rd_valid && !samp_ovf, "R9 flags after reset",
          {29'd0, wr_ready, rd_valid, samp_ovf}, 32'd4);
    rst = 1'b0;
    // R2: fill the output queue with a long divider, then offer a fifth word
    div_count = 8'd200; dir_mask = '1;
    put(32'hA1A1_0001); put(32'hB2B2_0002); put(32'hC3C3_0003); put(32'hD4D4_0004);
    check(!wr_ready, "R2 full queue drops ready", W'(wr_ready), '0);
    wr_valid = 1'b1; wr_data = 32'hEEEE_0005;
    repeat (3) step();
    check(pin_out == '0, "R2 held-off word leaves pins alone", pin_out, '0);
    wr_valid = 1'b0;
    // R3 R4: drain at one tick per cycle
    div_count = 8'd0;
    repeat (8) step();
    check(pin_out == 32'hD4D4_0004, "R4 last queued word applied", pin_out, 32'hD4D4_0004);
    // R3: spacing with N=3, measured on pin changes
    div_count = 8'd3;
    put(32'h1111_1111); put(32'h2222_2222);
    while (pin_out != 32'h1111_1111) step();
    n = 0;
    while (pin_out != 32'h2222_2222) begin step(); n++; end
    check(n == 4, "R3 tick spacing N+1", W'(n), 32'd4);
    // R6 R8: fill sample queue with mixed directions
    dir_mask = 32'h0000_FFFF; div_count = 8'd2;
    samp_en = 1'b1;
    for (int i = 0; i < 24; i++) begin pin_in = 32'h0101_0000 * (i + 1) + i; step(); end
    check(samp_ovf, "R8 overflow set when full", W'(samp_ovf), 32'd1);
    rd_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; step(); end
    rd_ready = 1'b0;
    for (int i = 0; i < 6; i++) step();
    check(samp_ovf, "R8 overflow sticky", W'(samp_ovf), 32'd1);
    samp_en = 1'b0;
    rd_ready = 1'b1;
    repeat (6) step();
    rd_ready = 1'b0;
    // R7: restart on enable, first sample after N+1 further edges
    div_count = 8'd3;
    samp_en = 1'b1;
    n = 0;
    do begin step(); n++; end while (!rd_valid && n < 50);
    check(n == 5, "R7 first sample after restart", W'(n), 32'd5);
    check(!samp_ovf, "R8 overflow cleared by enable", W'(samp_ovf), '0);
    // R5: direct view with mixed mask
    dir_mask = 32'hFF00_FF00; pin_in = 32'h1234_5678;
    step();
    check(direct_data == ((pin_out & 32'hFF00_FF00) | (32'h1234_5678 & 32'h00FF_00FF)),
          "R5 mixed direct view", direct_data,
          (pin_out & 32'hFF00_FF00) | (32'h1234_5678 & 32'h00FF_00FF));
    // random phase
    for (int i = 0; i < 600; i++) begin
      wr_valid = $urandom_range(0, 1) == 1;
      wr_data  = $urandom;
      rd_ready = $urandom_range(0, 3) == 0;
      pin_in   = $urandom;
      if ($urandom_range(0, 15) == 0) div_count = DW'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) dir_mask = $urandom;
      if ($urandom_range(0, 39) == 0) samp_en = ~samp_en;
      step();
    end
    wr_valid = 1'b0; rd_ready = 1'b0;
    repeat (4) step();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule